// File: doc/BRIEF.md
# RAM-Indexed Ternary Match Engine

This block provides ternary (0/1/don't-care) key lookup without a comparator per stored bit. The rule table is cut in two directions. Rows are grouped into layers of a fixed number of rules each. The key is sliced into equal subwords. Every layer keeps, for each subword, a small RAM addressed by that subword's value.

Each RAM word holds two things: one presence bit and a rule vector with one bit per rule of the layer. During a search, each layer reads one word per subword. It ANDs the presence bits together and ANDs the rule vectors together, so a rule survives only if every slice of the key agrees with it. A local priority encoder picks the surviving rule with the lowest index. A global encoder then picks the lowest-numbered layer that hit. The result is registered one clock after the key is presented.

Don't-care bits are resolved when a rule is loaded. A load sweeps every RAM address with an internal counter, so it takes one cycle per address of a subword RAM. While a load is running, `busy` is high, and new searches and new loads are not accepted.

Top module: `ztcam_engine`

## Requirements
- R1: A search accepted with `srch_en` high while `busy` is low drives `match_valid` and `match_addr` on the following clock edge. A key that equals a loaded rule's pattern on every unmasked bit produces `match_valid`=1.
- R2: A `wr_mask` bit of 1 marks that key bit as don't-care. Keys that differ from the pattern only in masked bits still match the rule.
- R3: Within one layer, when several rules match, the rule with the lowest index wins.
- R4: Rule index r lives in layer r / RULES at local slot r mod RULES, and `match_addr` = layer × RULES + local slot. When rules in different layers match, the lowest layer wins, so the smallest matching global index is reported.
- R5: A load accepted (`wr_en` high with `busy` low) raises `busy` on the next edge. `busy` stays high for exactly 2^SUB_W cycles. The new rule is visible to searches once `busy` is low again.
- R6: While `busy` is high, `srch_en` is ignored and `match_valid`/`match_addr` keep their previous values. The same holds when `srch_en` is low.
- R7: A search that matches no rule gives `match_valid`=0 and `match_addr`=0.
- R8: Loading a rule index again replaces that rule's old pattern and mask. The old pattern no longer matches through that index.
- R9: `wr_en` asserted while `busy` is high is ignored, and the table is not changed by it.
- R10: After reset, `busy`, `match_valid` and `match_addr` are 0 and the table holds no rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Start loading a rule |
| wr_rule | input | AW (4) | Global rule index to load |
| wr_pattern | input | KEY_W (16) | Rule pattern bits |
| wr_mask | input | KEY_W (16) | 1 = don't-care bit |
| srch_en | input | 1 | Present a search key |
| srch_key | input | KEY_W (16) | Key to look up |
| busy | output | 1 | Load sweep in progress |
| match_valid | output | 1 | Registered hit flag |
| match_addr | output | AW (4) | Registered winning global rule index |

## Verification
The hardest case to reach is a rule whose masked bits sit inside several subwords at once, so its presence is spread across many RAM addresses. The same case arises when an index is reloaded and its stale bits have to be cleared at every address the old pattern covered. The bench reaches both with directed loads followed by keys that flip only masked bits. It then runs a random phase that builds keys from stored patterns with their masked bits scrambled, and reloads indices that are already in use. Searches and second loads are also issued in the middle of a sweep, to show that they leave the outputs and the table untouched.

// File: rtl/ztc_pkg.sv
package ztc_pkg;
   // Index width for n items, never less than one bit.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ztc_prio_enc.sv
module ztc_prio_enc #(
   parameter int W  = 8,
   localparam int IW = ztc_pkg::idx_w(W)
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/ztc_layer.sv
module ztc_layer #(
   parameter int KEY_W = 16,
   parameter int SUB_W = 4,
   parameter int RULES = 8,
   localparam int NSUB  = KEY_W / SUB_W,
   localparam int DEPTH = 1 << SUB_W,
   localparam int LIW   = ztc_pkg::idx_w(RULES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_act,
   input  logic [SUB_W-1:0] wr_addr,
   input  logic [LIW-1:0]   wr_local,
   input  logic [KEY_W-1:0] wr_pat,
   input  logic [KEY_W-1:0] wr_msk,
   input  logic [KEY_W-1:0] key,
   output logic             hit,
   output logic [LIW-1:0]   local_idx
);
   logic [NSUB-1:0]  pres_rd;
   logic [RULES-1:0] vec_rd [NSUB];
   logic             all_pres;
   logic [RULES-1:0] match_vec;
   logic             any_rule;

   for (genvar s = 0; s < NSUB; s++) begin : g_sub
      logic [DEPTH-1:0] pres_ram;
      logic [RULES-1:0] vec_ram [DEPTH];
      logic             fits;
      logic [RULES-1:0] new_vec;

      always_comb begin
         fits    = ((wr_addr ^ wr_pat[s*SUB_W +: SUB_W]) & ~wr_msk[s*SUB_W +: SUB_W]) == '0;
         new_vec = vec_ram[wr_addr];
         new_vec[wr_local] = fits;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_ram <= '0;
            for (int d = 0; d < DEPTH; d++) vec_ram[d] <= '0;
         end else if (wr_act) begin
            pres_ram[wr_addr] <= |new_vec;
            vec_ram[wr_addr]  <= new_vec;
         end
      end

      assign pres_rd[s] = pres_ram[key[s*SUB_W +: SUB_W]];
      assign vec_rd[s]  = vec_ram[key[s*SUB_W +: SUB_W]];
   end

   always_comb begin
      all_pres  = &pres_rd;
      match_vec = {RULES{all_pres}};
      for (int s = 0; s < NSUB; s++) match_vec &= vec_rd[s];
   end

   ztc_prio_enc #(.W(RULES)) u_local_enc (
      .vec(match_vec),
      .idx(local_idx),
      .any(any_rule)
   );

   assign hit = all_pres & any_rule;
endmodule

// File: rtl/ztcam_engine.sv
module ztcam_engine #(
   parameter int KEY_W  = 16,
   parameter int SUB_W  = 4,
   parameter int LAYERS = 2,
   parameter int RULES  = 8,
   localparam int DEPTH = 1 << SUB_W,
   localparam int LIW   = ztc_pkg::idx_w(RULES),
   localparam int LYW   = ztc_pkg::idx_w(LAYERS),
   localparam int AW    = ztc_pkg::idx_w(LAYERS * RULES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_rule,
   input  logic [KEY_W-1:0] wr_pattern,
   input  logic [KEY_W-1:0] wr_mask,
   input  logic             srch_en,
   input  logic [KEY_W-1:0] srch_key,
   output logic             busy,
   output logic             match_valid,
   output logic [AW-1:0]    match_addr
);
   if (KEY_W % SUB_W != 0) begin : g_bad_split
      $error("KEY_W must be a multiple of SUB_W");
   end
   if ((1 << LIW) != RULES) begin : g_bad_rules
      $error("RULES must be a power of two");
   end
   if (SUB_W > 12) begin : g_bad_depth
      $error("SUB_W too large for register arrays");
   end

   logic [SUB_W-1:0] sweep_cnt;
   logic [AW-1:0]    rule_q;
   logic [KEY_W-1:0] pat_q;
   logic [KEY_W-1:0] msk_q;
   logic             done_sweep;

   assign done_sweep = (sweep_cnt == SUB_W'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         sweep_cnt <= '0;
         rule_q    <= '0;
         pat_q     <= '0;
         msk_q     <= '0;
      end else if (!busy) begin
         if (wr_en) begin
            busy      <= 1'b1;
            sweep_cnt <= '0;
            rule_q    <= wr_rule;
            pat_q     <= wr_pattern;
            msk_q     <= wr_mask;
         end
      end else if (done_sweep) begin
         busy <= 1'b0;
      end else begin
         sweep_cnt <= sweep_cnt + 1'b1;
      end
   end

   logic [31:0]      wr_layer;
   logic [LIW-1:0]   wr_local;
   logic [LAYERS-1:0] layer_hit;
   logic [LIW-1:0]   layer_idx [LAYERS];

   assign wr_layer = 32'(rule_q) >> LIW;
   assign wr_local = LIW'(rule_q);

   for (genvar l = 0; l < LAYERS; l++) begin : g_layer
      logic act;
      assign act = busy && (wr_layer == 32'(l));
      ztc_layer #(.KEY_W(KEY_W), .SUB_W(SUB_W), .RULES(RULES)) u_layer (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_act   (act),
         .wr_addr  (sweep_cnt),
         .wr_local (wr_local),
         .wr_pat   (pat_q),
         .wr_msk   (msk_q),
         .key      (srch_key),
         .hit      (layer_hit[l]),
         .local_idx(layer_idx[l])
      );
   end

   logic          any_hit;
   logic [AW-1:0] addr_next;

   if (LAYERS > 1) begin : g_global_enc
      logic [LYW-1:0] win_layer;
      ztc_prio_enc #(.W(LAYERS)) u_global_enc (
         .vec(layer_hit),
         .idx(win_layer),
         .any(any_hit)
      );
      assign addr_next = AW'(int'(win_layer) * RULES + int'(layer_idx[win_layer]));
   end else begin : g_single_layer
      assign any_hit   = layer_hit[0];
      assign addr_next = AW'(layer_idx[0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_valid <= 1'b0;
         match_addr  <= '0;
      end else if (srch_en && !busy) begin
         match_valid <= any_hit;
         match_addr  <= any_hit ? addr_next : '0;
      end
   end
endmodule

// File: rtl/ztcam_engine_chk.sv
module ztcam_engine_chk #(
   parameter int KEY_W  = 16,
   parameter int SUB_W  = 4,
   parameter int LAYERS = 2,
   parameter int RULES  = 8,
   localparam int DEPTH = 1 << SUB_W,
   localparam int AW    = ztc_pkg::idx_w(LAYERS * RULES)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          srch_en,
   input logic          busy,
   input logic          match_valid,
   input logic [AW-1:0] match_addr
);
   int busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else busy_run <= 0;
   end

   // R5: an accepted load raises busy next cycle
   a_r5_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy) |=> busy);

   // R5: sweep lasts exactly DEPTH cycles
   a_r5_sweep_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == DEPTH));

   a_r5_sweep_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < DEPTH));

   // R6: result holds when no search is accepted
   a_r6_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!srch_en || busy) |=> ($stable(match_valid) && $stable(match_addr)));

   // R7: no hit means zero address
   a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !match_valid |-> (match_addr == '0));

   // R4: address stays inside the table
   a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> (int'(match_addr) < LAYERS * RULES));
endmodule

bind ztcam_engine ztcam_engine_chk #(
   .KEY_W(KEY_W), .SUB_W(SUB_W), .LAYERS(LAYERS), .RULES(RULES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .srch_en    (srch_en),
   .busy       (busy),
   .match_valid(match_valid),
   .match_addr (match_addr)
);

// File: tb/ztcam_engine_test.sv
module ztcam_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int KEY_W = 16;
   localparam int NR    = 16;
   localparam int SWEEP = 16;
   localparam int AW    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [AW-1:0]    wr_rule = '0;
   logic [KEY_W-1:0] wr_pattern = '0;
   logic [KEY_W-1:0] wr_mask = '0;
   logic             srch_en = 1'b0;
   logic [KEY_W-1:0] srch_key = '0;
   logic             busy;
   logic             match_valid;
   logic [AW-1:0]    match_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ztcam_engine uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rule(wr_rule),
      .wr_pattern(wr_pattern), .wr_mask(wr_mask), .srch_en(srch_en),
      .srch_key(srch_key), .busy(busy), .match_valid(match_valid),
      .match_addr(match_addr)
   );

   // behavioural reference
   logic [KEY_W-1:0] m_pat [NR];
   logic [KEY_W-1:0] m_msk [NR];
   bit               m_used [NR];
   bit               e_valid;
   int               e_addr;
   int               e_left;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_valid = 0; e_addr = 0; e_left = 0;
         for (int i = 0; i < NR; i++) m_used[i] = 0;
      end else begin
         if (srch_en && e_left == 0) begin
            e_valid = 0; e_addr = 0;
            for (int i = NR - 1; i >= 0; i--)
               if (m_used[i] && (((srch_key ^ m_pat[i]) & ~m_msk[i]) == '0)) begin
                  e_valid = 1; e_addr = i;
               end
         end
         if (wr_en && e_left == 0) begin
            m_used[wr_rule] = 1;
            m_pat[wr_rule]  = wr_pattern;
            m_msk[wr_rule]  = wr_mask;
            e_left = SWEEP;
         end else if (e_left > 0) begin
            e_left--;
         end
      end
   end

   int    vectors = 0;
   int    fails = 0;
   int    cycles = 0;
   string tag = "R10";

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      cycles++;
      vectors++;
      if (busy !== (e_left > 0) || match_valid !== e_valid || int'(match_addr) !== e_addr) begin
         fails++;
         $display("FAIL %s cyc %0d: busy/valid/addr = %0b/%0b/%0d expected %0b/%0b/%0d",
                  tag, cycles, busy, match_valid, match_addr, (e_left > 0), e_valid, e_addr);
      end
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: run did not end, expected completion");
         finish_run();
      end
   end

   task automatic load(input int r, input logic [15:0] p, input logic [15:0] m);
      wr_en = 1; wr_rule = AW'(r); wr_pattern = p; wr_mask = m;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic settle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic look(input logic [15:0] k);
      srch_en = 1; srch_key = k;
      @(negedge clk);
      srch_en = 0;
   endtask

   initial begin
      tag = "R10";
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      tag = "R7";  look(16'h1234); look(16'h0000);
      tag = "R1";  load(3, 16'h1234, 16'h0000); settle();
      look(16'h1234);
      tag = "R7";  look(16'h1235); look(16'h9234);
      tag = "R2";  load(5, 16'hA0F0, 16'h0F0F); settle();
      look(16'hA3F9); look(16'hAFF0); look(16'hB0F0);
      tag = "R3";  load(1, 16'h12F0, 16'h00FF); settle();
      look(16'h1234); look(16'h12AB);
      load(10, 16'hABCD, 16'h0000); settle();
      load(9, 16'hAB00, 16'h00FF); settle();
      look(16'hABCD); look(16'hAB11);
      tag = "R4";  load(12, 16'h5555, 16'h0000); settle();
      look(16'h5555);
      load(6, 16'h5550, 16'h000F); settle();
      look(16'h5555); look(16'h555A);
      tag = "R8";  load(6, 16'h0000, 16'h0000); settle();
      look(16'h5555); look(16'h555A); look(16'h0000);
      tag = "R5";  load(7, 16'hC3C3, 16'h8181);
      repeat (SWEEP + 2) @(negedge clk);
      look(16'h4242);
      tag = "R6";  look(16'h1234);
      load(14, 16'hFFFF, 16'h0000);
      for (int i = 0; i < 10; i++) look(16'hFFFF);
      settle(); look(16'hFFFF);
      tag = "R9";  load(2, 16'h7777, 16'h0000);
      @(negedge clk);
      load(0, 16'h8888, 16'h0000);
      settle();
      look(16'h8888); look(16'h7777);
      tag = "R1";
      for (int n = 0; n < 400; n++) begin
         int r;
         r = $urandom_range(NR - 1);
         if ($urandom_range(9) < 2) begin
            logic [15:0] m;
            m = 16'($urandom) & 16'($urandom) & 16'($urandom);
            load(r, 16'($urandom), m);
            if ($urandom_range(1) == 1) look(16'($urandom));
            settle();
         end else if (m_used[r]) begin
            look(m_pat[r] ^ (16'($urandom) & m_msk[r]));
         end else begin
            look(16'($urandom));
         end
      end
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule